// File: doc/BRIEF.md
# Serial Status Readout Port

This block keeps a 32-bit status word and sends it out one bit at a time on a single active-low indication line. The line that normally selects the operating mode doubles as the shift clock. A first falling edge on that line opens a readout. The second falling edge presents bit S0, and each later falling edge moves on to the next bit. Every bit leaves with its polarity inverted, so a set bit pulls the line low.

The status word combines several kinds of field. Some fields mirror the live wake flags. Others are constants or fixed version codes. A sampled guardian-enable level fills one position. Eight sticky fields hold on to event flags (power-on, bus fault, over-temperature shutdown, over-temperature warning, transmit-enable timeout and three supply undervoltages) until they are read. When the shift line stays still for a set number of clock cycles, the readout is treated as finished. The block then gives a one-cycle strobe to the mode controller and clears each sticky field that was actually shifted out, provided its source flag has gone inactive. Outside a readout, the line carries an indication level that comes from elsewhere.

Top module: `serial_status_port`

## Requirements
- R1: While no readout is in progress, and also after the first falling edge of a readout but before the second, `ser_out` equals `idle_level`.
- R2: The second falling edge of `en_pin` in a readout drives `ser_out` to the inverse of bit S0. Each later falling edge drives the inverse of the next higher bit (`ser_out` = 0 means the bit is 1).
- R3: Bit S0 is the live `flag_lwake` and S1 is the live `flag_rwake`, both taken at the moment they are shifted. S2 always reads 1. S12 to S15 always read 0.
- R4: Bit S(3+i) is 1 when `flag_evt[i]` has been high at any clock since that bit was last cleared (i = 0 is power-on, i = 1 is bus error, up to i = 7 for the third undervoltage). A one-cycle pulse is enough to set it.
- R5: Bits S16 to S23 are `ver_analog[0]` to `ver_analog[7]`. Bits S24 to S31 are `ver_digital[0]` to `ver_digital[7]`.
- R6: S11 reads the `bge_pin` level captured at a rising edge of `en_pin` during a readout while `mode_normal` is 1. When `mode_normal` is 0, S11 reads 0.
- R7: When `en_pin` shows no edge for `IDLE_CYC` clock cycles during a readout, the readout ends. `rd_done` is high for exactly one cycle, and `ser_out` returns to `idle_level`.
- R8: At the end of a readout, each of S4 to S10 is cleared only if that bit was shifted out and its source flag is low. An unread bit, or a bit whose flag is still high, stays set.
- R9: S3 is never cleared by a readout.
- R10: After S31, further falling edges keep `ser_out` at the inverse of S31.
- R11: After reset, no readout is active, `ser_out` equals `idle_level`, every sticky bit is 0 and `rd_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Mode/shift-clock pin, asynchronous |
| bge_pin | input | 1 | Guardian-enable pin level |
| mode_normal | input | 1 | 1 when the device is in Normal mode |
| flag_lwake | input | 1 | Live local-wake flag |
| flag_rwake | input | 1 | Live remote-wake flag |
| flag_evt | input | 8 | Live event flags feeding sticky bits S3..S10 |
| ver_analog | input | 8 | Fixed analog version code |
| ver_digital | input | 8 | Fixed digital version code |
| idle_level | input | 1 | Indication level driven outside a readout |
| ser_out | output | 1 | Serial indication output (active low) |
| rd_done | output | 1 | One-cycle readout-finished strobe |

## Verification
An edge on `en_pin` passes through two synchronizer flops and an edge register. A new bit therefore appears on `ser_out` at the third rising clock edge after the pin changes. The bench holds each `en_pin` level for six cycles and samples on the falling clock edge after that. `rd_done` and the sticky clear arrive `IDLE_CYC` cycles after the last synchronized edge. The bench waits `IDLE_CYC` plus ten cycles before it checks the strobe count or starts the next readout. Sticky bits take a flag pulse one cycle after it rises, and the bench holds pulses for two cycles.

// File: rtl/sstat_pkg.sv
package sstat_pkg;
    localparam int NBITS     = 32;
    localparam int IDX_W     = $clog2(NBITS);
    localparam int STICKY_LO = 3;
    localparam int STICKY_N  = 8;
    localparam int BGE_POS   = 11;
    localparam int VA_LO     = 16;
    localparam int VD_LO     = 24;

    function automatic logic [NBITS-1:0] pack_status(
        input logic                lwake,
        input logic                rwake,
        input logic [STICKY_N-1:0] sticky,
        input logic                bge_bit,
        input logic [7:0]          va,
        input logic [7:0]          vd
    );
        logic [NBITS-1:0] w;
        w                              = '0;
        w[0]                           = lwake;
        w[1]                           = rwake;
        w[2]                           = 1'b1;
        w[STICKY_LO +: STICKY_N]       = sticky;
        w[BGE_POS]                     = bge_bit;
        w[VA_LO +: 8]                  = va;
        w[VD_LO +: 8]                  = vd;
        return w;
    endfunction
endpackage

// File: rtl/sstat_sync.sv
module sstat_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_q, st_d;
    logic [STAGES-1:0] chain_nx;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_nx[i] = pin_i;
            end else begin : g_rest
                assign chain_nx[i] = st_q.chain[i-1];
            end
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.chain = chain_nx;
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall_o = st_q.prev & ~st_q.chain[STAGES-1];
    assign rise_o = ~st_q.prev & st_q.chain[STAGES-1];
endmodule

// File: rtl/sstat_sticky.sv
module sstat_sticky #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] clr_mask_i,
    input  logic         clr_i,
    output logic [N-1:0] sticky_o
);
    logic [N-1:0] hold_q, hold_d;

    always_comb begin
        hold_d = hold_q;
        if (clr_i) hold_d = hold_d & ~clr_mask_i;
        hold_d = hold_d | flags_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign sticky_o = hold_q;
endmodule

// File: rtl/sstat_shifter.sv
module sstat_shifter
    import sstat_pkg::*;
#(
    parameter int IDLE_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             rise_i,
    input  logic [NBITS-1:0] status_i,
    input  logic             idle_lvl_i,
    input  logic             bge_i,
    input  logic             normal_i,
    output logic             ser_o,
    output logic             fin_o,
    output logic             done_o,
    output logic             act_o,
    output logic             started_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             bge_o
);
    localparam int TMR_W = (IDLE_CYC < 2) ? 1 : $clog2(IDLE_CYC);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(IDLE_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBITS - 1);

    typedef struct packed {
        logic             act;
        logic             started;
        logic [IDX_W-1:0] idx;
        logic             bitv;
        logic [TMR_W-1:0] tmr;
        logic             bge;
        logic             done;
    } shf_t;

    shf_t q, d;
    logic             fin;
    logic [IDX_W-1:0] idx_nx;

    assign idx_nx = q.idx + 1'b1;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        fin    = 1'b0;
        if (!q.act) begin
            if (fall_i) begin
                d.act     = 1'b1;
                d.started = 1'b0;
                d.idx     = '0;
                d.tmr     = '0;
            end
        end else begin
            if (fall_i || rise_i) begin
                d.tmr = '0;
            end else if (q.tmr == TMR_LAST) begin
                fin       = 1'b1;
                d.act     = 1'b0;
                d.started = 1'b0;
                d.idx     = '0;
                d.done    = 1'b1;
            end else begin
                d.tmr = q.tmr + 1'b1;
            end
            if (fall_i) begin
                if (!q.started) begin
                    d.started = 1'b1;
                    d.idx     = '0;
                    d.bitv    = ~status_i[0];
                end else if (q.idx != IDX_LAST) begin
                    d.idx  = idx_nx;
                    d.bitv = ~status_i[idx_nx];
                end
            end
            if (rise_i && normal_i) d.bge = bge_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ser_o     = q.started ? q.bitv : idle_lvl_i;
    assign fin_o     = fin;
    assign done_o    = q.done;
    assign act_o     = q.act;
    assign started_o = q.started;
    assign idx_o     = q.idx;
    assign bge_o     = q.bge;
endmodule

// File: rtl/serial_status_port.sv
module serial_status_port
    import sstat_pkg::*;
#(
    parameter int IDLE_CYC    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_pin,
    input  logic       bge_pin,
    input  logic       mode_normal,
    input  logic       flag_lwake,
    input  logic       flag_rwake,
    input  logic [7:0] flag_evt,
    input  logic [7:0] ver_analog,
    input  logic [7:0] ver_digital,
    input  logic       idle_level,
    output logic       ser_out,
    output logic       rd_done
);
    logic                fall_w, rise_w;
    logic                fin_w, act_w, started_w, bge_w;
    logic [IDX_W-1:0]    idx_w;
    logic [STICKY_N-1:0] sticky_w, clr_mask_w;
    logic [NBITS-1:0]    status_w;

    sstat_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (en_pin),
        .fall_o (fall_w),
        .rise_o (rise_w)
    );

    generate
        for (genvar j = 0; j < STICKY_N; j++) begin : g_clr
            if (j == 0) begin : g_keep
                assign clr_mask_w[j] = 1'b0;
            end else begin : g_sel
                assign clr_mask_w[j] = started_w && (idx_w >= IDX_W'(STICKY_LO + j));
            end
        end
    endgenerate

    sstat_sticky #(.N(STICKY_N)) u_sticky (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_i    (flag_evt),
        .clr_mask_i (clr_mask_w),
        .clr_i      (fin_w),
        .sticky_o   (sticky_w)
    );

    assign status_w = pack_status(flag_lwake, flag_rwake, sticky_w,
                                  mode_normal & bge_w, ver_analog, ver_digital);

    sstat_shifter #(.IDLE_CYC(IDLE_CYC)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall_w),
        .rise_i     (rise_w),
        .status_i   (status_w),
        .idle_lvl_i (idle_level),
        .bge_i      (bge_pin),
        .normal_i   (mode_normal),
        .ser_o      (ser_out),
        .fin_o      (fin_w),
        .done_o     (rd_done),
        .act_o      (act_w),
        .started_o  (started_w),
        .idx_o      (idx_w),
        .bge_o      (bge_w)
    );
endmodule

// File: rtl/sstat_chk.sv
module sstat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_done,
    input logic       act,
    input logic       started,
    input logic       fall_ev,
    input logic       ser_out,
    input logic       idle_level,
    input logic [7:0] flag_evt,
    input logic [7:0] sticky
);
    // R7: the finish strobe lasts one cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R7: a finish only follows an active readout
    assert_done_after_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> ($past(act) && !act));

    // R1: outside a readout the line carries the external level
    assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !rd_done) |-> (ser_out == idle_level));

    // R2: the shifted bit only moves on a falling edge
    assert_shift_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(started) && !$past(fall_ev)) |-> $stable(ser_out));

    // R4: any flag pulse is captured the next cycle
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_evt) |=> ((sticky & $past(flag_evt)) == $past(flag_evt)));

    // R9: the power-on bit never drops
    assert_por_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sticky[0]) |-> sticky[0]);
endmodule

bind serial_status_port sstat_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_done    (rd_done),
    .act        (act_w),
    .started    (started_w),
    .fall_ev    (fall_w),
    .ser_out    (ser_out),
    .idle_level (idle_level),
    .flag_evt   (flag_evt),
    .sticky     (sticky_w)
);

// File: tb/sim_serial_status_port.sv
module sim_serial_status_port;
    localparam int IDLE_CYC = 64;
    localparam int HOLD     = 6;
    localparam int NVEC     = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_pin = 1'b1;
    logic       bge_pin = 1'b0;
    logic       mode_normal = 1'b1;
    logic       flag_lwake = 1'b0;
    logic       flag_rwake = 1'b0;
    logic [7:0] flag_evt = '0;
    logic [7:0] ver_analog = '0;
    logic [7:0] ver_digital = '0;
    logic       idle_level = 1'b1;
    logic       ser_out;
    logic       rd_done;

    int n_chk = 0;
    int n_err = 0;
    int n_done = 0;
    logic [39:0] got;

    always #2 clk = ~clk;

    serial_status_port #(.IDLE_CYC(IDLE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .bge_pin(bge_pin),
        .mode_normal(mode_normal), .flag_lwake(flag_lwake), .flag_rwake(flag_rwake),
        .flag_evt(flag_evt), .ver_analog(ver_analog), .ver_digital(ver_digital),
        .idle_level(idle_level), .ser_out(ser_out), .rd_done(rd_done)
    );

    always @(posedge clk) if (rst_n && rd_done) n_done++;

    // fields: [27] lwake [26] rwake [25:18] evt [17] bge [16] normal [15:8] va [7:0] vd
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00},
        {1'b1, 1'b0, 8'h02, 1'b1, 1'b1, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 8'hF0, 1'b1, 1'b0, 8'h81, 8'h7E},
        {1'b1, 1'b1, 8'h0E, 1'b0, 1'b1, 8'hFF, 8'h01},
        {1'b0, 1'b0, 8'hFE, 1'b1, 1'b1, 8'h12, 8'h80},
        {1'b1, 1'b0, 8'h54, 1'b0, 1'b0, 8'h6B, 8'hD9}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic en_set(input logic v);
        en_pin = v;
        repeat (HOLD) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic [7:0] m);
        @(negedge clk);
        flag_evt = m;
        repeat (2) @(negedge clk);
        flag_evt = '0;
        @(negedge clk);
    endtask

    task automatic readout(input int nbits);
        got = '0;
        en_set(1'b0);
        for (int k = 0; k < nbits; k++) begin
            en_set(1'b1);
            en_set(1'b0);
            got[k] = ~ser_out;
        end
        en_set(1'b1);
        repeat (IDLE_CYC + 10) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int dprev;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ser_out in reset", {31'b0, ser_out}, {31'b0, idle_level});
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 no strobe after reset", n_done, 0);
        idle_level = 1'b0;
        @(negedge clk);
        chk("R1 idle level low", {31'b0, ser_out}, 32'd0);
        idle_level = 1'b1;
        @(negedge clk);
        chk("R1 idle level high", {31'b0, ser_out}, 32'd1);
        readout(32);
        chk("R11 sticky clear after reset", {24'b0, got[10:3]}, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            logic [27:0] e;
            e           = VEC[v];
            flag_lwake  = e[27];
            flag_rwake  = e[26];
            bge_pin     = e[17];
            mode_normal = e[16];
            ver_analog  = e[15:8];
            ver_digital = e[7:0];
            pulse_evt(e[25:18]);
            dprev = n_done;
            readout(32);
            chk("R3 S0..S2", {29'b0, got[2:0]}, {29'b0, 1'b1, e[26], e[27]});
            chk("R4 S3..S10", {24'b0, got[10:3]}, {24'b0, e[25:18]});
            chk("R6 S11", {31'b0, got[11]}, {31'b0, e[17] & e[16]});
            chk("R3 S12..S15", {28'b0, got[15:12]}, 32'd0);
            chk("R5 versions", {16'b0, got[31:16]}, {16'b0, e[7:0], e[15:8]});
            chk("R7 one strobe", n_done - dprev, 1);
            chk("R7 line back idle", {31'b0, ser_out}, {31'b0, idle_level});
        end

        // R1 after first fall only; R7 timeout end with no bits
        mode_normal = 1'b1;
        idle_level  = 1'b0;
        en_set(1'b0);
        chk("R1 after first fall", {31'b0, ser_out}, 32'd0);
        en_set(1'b1);
        repeat (IDLE_CYC + 10) @(negedge clk);
        idle_level = 1'b1;
        @(negedge clk);
        chk("R1 idle after short readout", {31'b0, ser_out}, 32'd1);

        // R8 partial read keeps unread S5
        pulse_evt(8'h04);
        readout(3);
        readout(32);
        chk("R8 unread S5 kept", {31'b0, got[5]}, 32'd1);
        readout(32);
        chk("R8 read S5 cleared", {31'b0, got[5]}, 32'd0);

        // R8 active flag keeps S6
        flag_evt = 8'h08;
        readout(32);
        flag_evt = '0;
        @(negedge clk);
        readout(32);
        chk("R8 active flag S6 kept", {31'b0, got[6]}, 32'd1);
        readout(32);
        chk("R8 S6 cleared later", {31'b0, got[6]}, 32'd0);

        // R9 power-on bit persists
        pulse_evt(8'h01);
        readout(32);
        readout(32);
        chk("R9 S3 kept", {31'b0, got[3]}, 32'd1);

        // R10 saturation
        ver_digital = 8'h80;
        readout(34);
        chk("R10 bits past S31", {30'b0, got[33:32]}, {30'b0, got[31], got[31]});
        chk("R10 S31 value", {31'b0, got[31]}, 32'd1);
        ver_digital = 8'h00;
        readout(34);
        chk("R10 bits past S31 low", {30'b0, got[33:32]}, 32'd0);

        finish_run();
    end
endmodule